// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gating

This block sits between a set of free-running clock sources and the clock pins of a system clock generator. It passes each source to its pins and silences it on two active-low controls. The first is a processor-stop control, which halts only the processor clocks. The second is a power-down control, which halts everything.

The sources are:
- a processor clock, driven out as a true/complement pair plus a chipset copy;
- a PCI clock fanned out to several pins;
- an externally supplied memory clock fanned out to thirteen buffered pins;
- a 48 MHz clock;
- a Super I/O clock that is either the 48 MHz clock or half of it;
- a reference clock.

Every pin keeps a clean waveform across start and stop, with no shortened pulse. To achieve this, each control is brought into the clock domain it gates with a two-stage synchroniser. The true-phase enable changes only while its clock is low.

The processor pair does not stop symmetrically. The true output and the chipset copy are held low, while the complement output is released to high impedance. A strapped mode bit decides what one shared pin does. In one mode it drives a reference clock. In the other it is read as the processor-stop input, and the block stops driving it. Only the complement output and the shared pin can float, so only those two carry an output-enable; all other pins are always driven.

Top module: `clkout_gate`

## Requirements
- R1: While `rst_ni` is low, every clock output is 0, `cpu_clk_c_oe_o` is 0, and all internal enables and the divider are cleared.
- R2: With power-down released and the processor clocks not stopped, `cpu_clk_t_o` and `cs_clk_o` follow `cpu_clk_i` with identical phase, and `cpu_clk_c_o` is its inverse with `cpu_clk_c_oe_o` = 1.
- R3: When `mode_i` = 1 and `stop_pin_ni` = 0, `cpu_clk_t_o` and `cs_clk_o` are held at 0 and `cpu_clk_c_oe_o` goes to 0; the other clocks keep running.
- R4: When `pwr_dn_ni` = 0, `cpu_clk_c_oe_o` is 0 and every other clock output is held at 0.
- R5: Each of the `NUM_MEM` bits of `mem_clk_o` copies `mem_clk_i` while power-down is released, and is 0 during power-down.
- R6: Each of the `NUM_PCI` bits of `pci_clk_o` copies `pci_clk_i` while power-down is released, and is 0 during power-down.
- R7: With `mode_i` = 1, `ref0_oe_o` = 0 and `ref0_clk_o` = 0. With `mode_i` = 0, `ref0_oe_o` = 1, `ref0_clk_o` equals `ref1_clk_o` (the gated `ref_clk_i`), and `stop_pin_ni` has no effect on the processor outputs.
- R8: With `sio_sel48_i` = 0, `sio_clk_o` is `usb_clk_i` divided by two. The divider toggles on each rising edge of `usb_clk_i` at which the 48 MHz enable is set, and clears to 0 otherwise. With `sio_sel48_i` = 1, `sio_clk_o` equals `usb_clk_o`.
- R9: A control change is captured over two rising edges of the gated source. The true-phase enable then updates at the next falling edge, and the complement enable one rising edge after that. As a result, every output pulse is a full source half-period.
- R10: Power-down takes priority over stop: while `pwr_dn_ni` = 0, releasing `stop_pin_ni` does not restart the processor clocks.
- R11: `usb_clk_o` copies `usb_clk_i` while power-down is released, and is 0 during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Latched strap: 1 = shared pin is the stop input, 0 = reference output |
| pwr_dn_ni | input | 1 | Active-low power-down |
| stop_pin_ni | input | 1 | Value read from the shared pin (active-low processor stop) |
| sio_sel48_i | input | 1 | Super I/O clock select: 0 = 24 MHz, 1 = 48 MHz |
| cpu_clk_i | input | 1 | Processor clock source |
| pci_clk_i | input | 1 | PCI clock source |
| mem_clk_i | input | 1 | Memory clock input for fan-out |
| usb_clk_i | input | 1 | 48 MHz clock source |
| ref_clk_i | input | 1 | Reference clock source |
| cpu_clk_t_o | output | 1 | Processor clock, true |
| cpu_clk_c_o | output | 1 | Processor clock, complement |
| cpu_clk_c_oe_o | output | 1 | Drive enable of the complement pin |
| cs_clk_o | output | 1 | Chipset copy of the true processor clock |
| pci_clk_o | output | NUM_PCI | PCI clock copies |
| mem_clk_o | output | NUM_MEM | Buffered memory clock copies |
| usb_clk_o | output | 1 | 48 MHz output |
| sio_clk_o | output | 1 | 24/48 MHz Super I/O output |
| ref1_clk_o | output | 1 | Dedicated reference output |
| ref0_clk_o | output | 1 | Shared pin, reference value |
| ref0_oe_o | output | 1 | Drive enable of the shared pin |

## Verification
A control that changes between edges reaches the true-phase outputs in one of two ways. A stop takes effect at the falling edge that follows the second rising edge of that domain's source. A start shows on the third rising edge. The complement enable follows one rising edge later, and the divided Super I/O clock moves on the first rising edge after its enable. The bench applies controls 0.75 ns before a source edge. It advances a behavioural model on the same edges and compares every output 1 ns after each edge, so each result is checked in exactly the half-cycle it is due. The checker counts consecutive source rising edges with a control held, and asserts the settled levels only once that count reaches three.

// File: rtl/cgate_pkg.sv
`timescale 1ns/1ps
package cgate_pkg;
  typedef enum logic {
    PIN_REF_OUT = 1'b0,
    PIN_STOP_IN = 1'b1
  } shared_pin_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cgate_cell.sv
`timescale 1ns/1ps
// Synchronises an asynchronous enable into clk_i's domain and produces
// glitch-free gating enables for the true and (optionally) complement phase.
module cgate_cell #(
  parameter int STAGES   = 2,
  parameter bit HAS_COMP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_lo_o,
  output logic en_hi_o
);
  logic [STAGES-1:0] sync_q;
  logic              en_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], en_i};
  end

  // true phase: update while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b0;
    else         en_lo_q <= sync_q[STAGES-1];
  end

  assign en_lo_o = en_lo_q;

  generate
    if (HAS_COMP) begin : g_comp
      logic en_hi_q;
      // complement phase: update while the inverted clock is low
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_hi_q <= 1'b0;
        else         en_hi_q <= en_lo_q;
      end
      assign en_hi_o = en_hi_q;
    end else begin : g_nocomp
      assign en_hi_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cgate_div.sv
`timescale 1ns/1ps
// Divide-by-two that parks low when disabled; starts and stops on full halves.
module cgate_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= ~q_q;
    else           q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate
  import cgate_pkg::*;
#(
  parameter int NUM_PCI = 6,
  parameter int NUM_MEM = 13
) (
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               pwr_dn_ni,
  input  logic               stop_pin_ni,
  input  logic               sio_sel48_i,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               mem_clk_i,
  input  logic               usb_clk_i,
  input  logic               ref_clk_i,
  output logic               cpu_clk_t_o,
  output logic               cpu_clk_c_o,
  output logic               cpu_clk_c_oe_o,
  output logic               cs_clk_o,
  output logic [NUM_PCI-1:0] pci_clk_o,
  output logic [NUM_MEM-1:0] mem_clk_o,
  output logic               usb_clk_o,
  output logic               sio_clk_o,
  output logic               ref1_clk_o,
  output logic               ref0_clk_o,
  output logic               ref0_oe_o
);
  shared_pin_e pin_mode;
  logic        stop_n_int, cpu_run;
  logic        cpu_en_lo, cpu_en_hi;
  logic        pci_en, mem_en, usb_en, ref_en;
  logic        unused_hi_pci, unused_hi_mem, unused_hi_usb, unused_hi_ref;
  logic        sio_div;
  logic        ref_gated;

  assign pin_mode   = shared_pin_e'(mode_i);
  // reference mode: stop held deasserted
  assign stop_n_int = (pin_mode == PIN_STOP_IN) ? stop_pin_ni : 1'b1;
  // power-down dominates stop
  assign cpu_run    = pwr_dn_ni & stop_n_int;

  cgate_cell #(.STAGES(SYNC_STAGES), .HAS_COMP(1'b1)) u_cpu (
    .clk_i(cpu_clk_i), .rst_ni(rst_ni), .en_i(cpu_run),
    .en_lo_o(cpu_en_lo), .en_hi_o(cpu_en_hi));

  cgate_cell #(.STAGES(SYNC_STAGES), .HAS_COMP(1'b0)) u_pci (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .en_i(pwr_dn_ni),
    .en_lo_o(pci_en), .en_hi_o(unused_hi_pci));

  cgate_cell #(.STAGES(SYNC_STAGES), .HAS_COMP(1'b0)) u_mem (
    .clk_i(mem_clk_i), .rst_ni(rst_ni), .en_i(pwr_dn_ni),
    .en_lo_o(mem_en), .en_hi_o(unused_hi_mem));

  cgate_cell #(.STAGES(SYNC_STAGES), .HAS_COMP(1'b0)) u_usb (
    .clk_i(usb_clk_i), .rst_ni(rst_ni), .en_i(pwr_dn_ni),
    .en_lo_o(usb_en), .en_hi_o(unused_hi_usb));

  cgate_cell #(.STAGES(SYNC_STAGES), .HAS_COMP(1'b0)) u_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(pwr_dn_ni),
    .en_lo_o(ref_en), .en_hi_o(unused_hi_ref));

  cgate_div u_sio_div (
    .clk_i(usb_clk_i), .rst_ni(rst_ni), .en_i(usb_en), .q_o(sio_div));

  assign cpu_clk_t_o    = cpu_clk_i & cpu_en_lo;
  assign cs_clk_o       = cpu_clk_i & cpu_en_lo;
  assign cpu_clk_c_o    = ~cpu_clk_i & cpu_en_hi;
  assign cpu_clk_c_oe_o = cpu_en_hi;

  generate
    for (genvar g = 0; g < NUM_PCI; g++) begin : g_pci
      assign pci_clk_o[g] = pci_clk_i & pci_en;
    end
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
      assign mem_clk_o[g] = mem_clk_i & mem_en;
    end
  endgenerate

  assign usb_clk_o  = usb_clk_i & usb_en;
  assign sio_clk_o  = sio_sel48_i ? usb_clk_o : sio_div;

  assign ref_gated  = ref_clk_i & ref_en;
  assign ref1_clk_o = ref_gated;
  assign ref0_clk_o = (pin_mode == PIN_REF_OUT) ? ref_gated : 1'b0;
  assign ref0_oe_o  = (pin_mode == PIN_REF_OUT);
endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk #(
  parameter int NUM_PCI = 6,
  parameter int NUM_MEM = 13
) (
  input logic               rst_ni,
  input logic               mode_i,
  input logic               pwr_dn_ni,
  input logic               stop_pin_ni,
  input logic               cpu_clk_i,
  input logic               pci_clk_i,
  input logic               mem_clk_i,
  input logic               ref_clk_i,
  input logic               cpu_clk_t_o,
  input logic               cpu_clk_c_oe_o,
  input logic               cs_clk_o,
  input logic [NUM_PCI-1:0] pci_clk_o,
  input logic [NUM_MEM-1:0] mem_clk_o,
  input logic               ref0_clk_o,
  input logic               ref0_oe_o
);
  logic      want_run;
  logic [1:0] cpu_off_n, cpu_on_n, pci_off_n, mem_off_n, mem_on_n;

  assign want_run = pwr_dn_ni && (!mode_i || stop_pin_ni);

  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_off_n <= '0; cpu_on_n <= '0;
    end else begin
      cpu_off_n <= want_run ? 2'd0 : (cpu_off_n == 2'd3 ? 2'd3 : cpu_off_n + 2'd1);
      cpu_on_n  <= !want_run ? 2'd0 : (cpu_on_n == 2'd3 ? 2'd3 : cpu_on_n + 2'd1);
    end
  end

  always_ff @(posedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) pci_off_n <= '0;
    else pci_off_n <= pwr_dn_ni ? 2'd0 : (pci_off_n == 2'd3 ? 2'd3 : pci_off_n + 2'd1);
  end

  always_ff @(posedge mem_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_off_n <= '0; mem_on_n <= '0;
    end else begin
      mem_off_n <= pwr_dn_ni ? 2'd0 : (mem_off_n == 2'd3 ? 2'd3 : mem_off_n + 2'd1);
      mem_on_n  <= !pwr_dn_ni ? 2'd0 : (mem_on_n == 2'd3 ? 2'd3 : mem_on_n + 2'd1);
    end
  end

  AST_CPU_HALTED: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_off_n == 2'd3) |-> (!cpu_clk_t_o && !cs_clk_o && !cpu_clk_c_oe_o)); // R3

  AST_CPU_RUNNING: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_on_n == 2'd3) |-> (cpu_clk_t_o && cs_clk_o && cpu_clk_c_oe_o)); // R2

  AST_PCI_PD_LOW: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_off_n == 2'd3) |-> (pci_clk_o == '0)); // R6

  AST_MEM_PD_LOW: assert property (@(negedge mem_clk_i) disable iff (!rst_ni)
    (mem_off_n == 2'd3) |-> (mem_clk_o == '0)); // R5

  AST_MEM_COPY: assert property (@(negedge mem_clk_i) disable iff (!rst_ni)
    (mem_on_n == 2'd3) |-> (mem_clk_o == '1)); // R5

  AST_SHARED_PIN_INPUT: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    mode_i |-> (!ref0_oe_o && !ref0_clk_o)); // R7
endmodule

bind clkout_gate clkout_gate_chk #(.NUM_PCI(NUM_PCI), .NUM_MEM(NUM_MEM)) u_chk (
  .rst_ni(rst_ni), .mode_i(mode_i), .pwr_dn_ni(pwr_dn_ni), .stop_pin_ni(stop_pin_ni),
  .cpu_clk_i(cpu_clk_i), .pci_clk_i(pci_clk_i), .mem_clk_i(mem_clk_i),
  .ref_clk_i(ref_clk_i), .cpu_clk_t_o(cpu_clk_t_o), .cpu_clk_c_oe_o(cpu_clk_c_oe_o),
  .cs_clk_o(cs_clk_o), .pci_clk_o(pci_clk_o), .mem_clk_o(mem_clk_o),
  .ref0_clk_o(ref0_clk_o), .ref0_oe_o(ref0_oe_o));

// File: tb/tb_clkout_gate.sv
`timescale 1ns/10ps
module tb_clkout_gate;
  localparam int NP = 6;
  localparam int NM = 13;

  logic rst_ni, mode_i, pwr_dn_ni, stop_pin_ni, sio_sel48_i;
  logic clk, pci_clk, mem_clk, usb_clk, ref_clk;
  logic cpu_t, cpu_c, cpu_c_oe, cs_clk, usb_o, sio_o, ref1_o, ref0_o, ref0_oe;
  logic [NP-1:0] pci_o;
  logic [NM-1:0] mem_o;

  clkout_gate #(.NUM_PCI(NP), .NUM_MEM(NM)) dut (
    .rst_ni(rst_ni), .mode_i(mode_i), .pwr_dn_ni(pwr_dn_ni), .stop_pin_ni(stop_pin_ni),
    .sio_sel48_i(sio_sel48_i), .cpu_clk_i(clk), .pci_clk_i(pci_clk), .mem_clk_i(mem_clk),
    .usb_clk_i(usb_clk), .ref_clk_i(ref_clk), .cpu_clk_t_o(cpu_t), .cpu_clk_c_o(cpu_c),
    .cpu_clk_c_oe_o(cpu_c_oe), .cs_clk_o(cs_clk), .pci_clk_o(pci_o), .mem_clk_o(mem_o),
    .usb_clk_o(usb_o), .sio_clk_o(sio_o), .ref1_clk_o(ref1_o), .ref0_clk_o(ref0_o),
    .ref0_oe_o(ref0_oe));

  // domains: 0 cpu, 1 pci, 2 mem, 3 usb, 4 ref
  bit   src [5];
  bit   seen[5][$];   // enable values captured at rising edges, newest last
  bit   lo  [5];
  bit   hi_c, div24;
  int   tick = 0;
  int   vectors = 0, miscompares = 0;
  string req = "R1";

  function automatic bit want_en(int d);
    if (d == 0) return pwr_dn_ni && (!mode_i || stop_pin_ni);
    return pwr_dn_ni;
  endfunction

  function automatic bit old_en(int d);
    if (seen[d].size() < 2) return 1'b0;
    return seen[d][seen[d].size()-2];
  endfunction

  task automatic model_edge(int d, bit nv);
    if (nv && !src[d]) begin
      if (d == 0) hi_c = lo[0];
      if (d == 3) div24 = lo[3] ? !div24 : 1'b0;
      seen[d].push_back(want_en(d));
      if (seen[d].size() > 2) void'(seen[d].pop_front());
    end else if (!nv && src[d]) begin
      lo[d] = seen[d].size() == 2 ? seen[d][0] : 1'b0;
    end
    src[d] = nv;
  endtask

  task automatic model_reset();
    for (int d = 0; d < 5; d++) begin
      lo[d] = 1'b0;
      seen[d].delete();
    end
    hi_c = 1'b0; div24 = 1'b0;
  endtask

  task automatic cmp(string name, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s tick %0d: got %0h expected %0h", req, name, tick, got, exp);
    end
  endtask

  task automatic compare_all();
    bit eusb;
    eusb = src[3] & lo[3];
    cmp("cpu_clk_t_o",    32'(cpu_t),    32'(src[0] & lo[0]));
    cmp("cs_clk_o",       32'(cs_clk),   32'(src[0] & lo[0]));
    cmp("cpu_clk_c_o",    32'(cpu_c),    32'(!src[0] & hi_c));
    cmp("cpu_clk_c_oe_o", 32'(cpu_c_oe), 32'(hi_c));
    cmp("pci_clk_o",      32'(pci_o),    (src[1] & lo[1]) ? 32'((1 << NP) - 1) : 32'd0);
    cmp("mem_clk_o",      32'(mem_o),    (src[2] & lo[2]) ? 32'((1 << NM) - 1) : 32'd0);
    cmp("usb_clk_o",      32'(usb_o),    32'(eusb));
    cmp("sio_clk_o",      32'(sio_o),    32'(sio_sel48_i ? eusb : div24));
    cmp("ref1_clk_o",     32'(ref1_o),   32'(src[4] & lo[4]));
    cmp("ref0_clk_o",     32'(ref0_o),   32'(mode_i ? 1'b0 : (src[4] & lo[4])));
    cmp("ref0_oe_o",      32'(ref0_oe),  32'(!mode_i));
  endtask

  // one half-tick of 2.5 ns: inputs settle 0.75 ns before the edge, compare 1 ns after
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      #0.75;
      tick++;
      model_edge(0, !src[0]);
      if (tick % 2 == 0) model_edge(1, !src[1]);
      model_edge(2, !src[0]);
      if (tick % 3 == 0) model_edge(3, !src[3]);
      if (tick % 4 == 0) model_edge(4, !src[4]);
      if (!rst_ni) model_reset();
      clk = src[0]; pci_clk = src[1]; mem_clk = src[2]; usb_clk = src[3]; ref_clk = src[4];
      #1;
      compare_all();
      #0.75;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired at tick %0d", tick);
    finish_run();
  end

  initial begin
    src[0] = 0; src[1] = 0; src[2] = 1; src[3] = 0; src[4] = 0;
    clk = 0; pci_clk = 0; mem_clk = 1; usb_clk = 0; ref_clk = 0;
    model_reset();
    rst_ni = 0; mode_i = 1; pwr_dn_ni = 1; stop_pin_ni = 1; sio_sel48_i = 0;
    req = "R1"; run(12);                       // reset: all quiet, complement floating
    rst_ni = 1;
    req = "R2"; run(40);                       // processor pair, chipset copy running
    req = "R8"; run(24);                       // 24 MHz from divided 48 MHz
    req = "R3"; stop_pin_ni = 0; run(30);      // stop: true/chipset low, complement floats
    req = "R9"; stop_pin_ni = 1; run(30);      // restart on whole pulses
    req = "R8"; sio_sel48_i = 1; run(24);      // Super I/O at 48 MHz
    req = "R4"; pwr_dn_ni = 0; run(40);        // power-down of all outputs
    req = "R5"; run(8);
    req = "R6"; run(8);
    req = "R11"; run(8);
    req = "R10"; stop_pin_ni = 0; run(10);
    stop_pin_ni = 1; run(20);                  // stop release alone does not restart
    stop_pin_ni = 0; pwr_dn_ni = 1; run(20);   // still stopped by stop pin
    stop_pin_ni = 1; run(20);
    req = "R7"; mode_i = 0; stop_pin_ni = 0; run(40); // reference out, stop pin ignored
    req = "R5"; sio_sel48_i = 0; run(20);
    req = "R9";
    for (int k = 0; k < 12; k++) begin         // fast toggling of power-down
      pwr_dn_ni = !pwr_dn_ni;
      run(1 + (k % 3));
    end
    pwr_dn_ni = 1; run(30);
    req = "R7"; mode_i = 1; stop_pin_ni = 1; run(20);
    req = "R1"; rst_ni = 0; run(10);
    rst_ni = 1; run(20);
    finish_run();
  end
endmodule